// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Generator

This block produces the raw transmit and raw receive interrupt flags of a UART. It watches the fill levels of the two 16-entry FIFOs. A flag sets only when a FIFO push or pop carries the occupancy across a selected fraction of the depth. Sitting past that fraction never sets it. A 6-bit level-select register holds one 3-bit code per direction.

The transmit flag has a second mode. When end-of-transmission mode is on, the transmit code is not used. The flag then waits until the TX FIFO holds nothing and the transmit serializer reports idle, which means the last stop bit has been shifted out.

Both flags are sticky. Each is cleared by its own write-one-to-clear pulse. The FIFOs, the serializer, the interrupt mask and the interrupt combining logic live outside this block.

Top module: `uart_fifo_level_irq`

## Requirements
- R1: After reset the level register reads 6'h12, so both fields hold code 2, and both `tx_irq` and `rx_irq` are 0.
- R2: `cfg_wdata[2:0]` is the transmit code and `cfg_wdata[5:3]` is the receive code. A write with `cfg_we` high is visible on `cfg_rdata` from the next cycle, bit for bit, and this includes reserved codes.
- R3: The receive fill thresholds for codes 0, 1, 2, 3 and 4 are 2, 4, 8, 12 and 14 entries (DEPTH=16). `rx_count` is the occupancy before the push. A cycle with `rx_push` high and `rx_count` equal to threshold−1 sets `rx_irq` at the next clock edge. A push at any other count does not set it.
- R4: The transmit fill thresholds for codes 0, 1, 2, 3 and 4 are 2, 4, 8, 12 and 14 entries. These correspond to the FIFO being at most 7/8, 3/4, 1/2, 1/4 and 1/8 empty. `tx_count` is the occupancy before the pop. With end-of-transmission mode off, a cycle with `tx_pop` high and `tx_count` equal to threshold+1 sets `tx_irq` at the next clock edge. A pop at any other count does not set it.
- R5: A count held at, above or below a threshold without a push or pop never sets a flag.
- R6: Codes 5, 6 and 7 never set the flag of their direction.
- R7: When `eot_mode` is 1, the transmit code and `tx_pop` are ignored. `tx_irq` sets one cycle after the condition (`tx_count`==0 and `ser_idle`==1) goes from false to true. It is not set again while that condition stays true.
- R8: A flag stays set until a cycle with its clear input high, after which it reads 0. If a set event falls in the same cycle as the clear, the flag stays 1.
- R9: A register write alone never sets a flag. A push or pop in the same cycle as the write is judged against the old code. The new code applies from the next push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Level register write enable |
| cfg_wdata | input | 6 | Level register write data: [2:0] transmit code, [5:3] receive code |
| cfg_rdata | output | 6 | Level register contents |
| tx_count | input | 5 | TX FIFO occupancy before this cycle's pop |
| tx_pop | input | 1 | TX FIFO pop strobe |
| rx_count | input | 5 | RX FIFO occupancy before this cycle's push |
| rx_push | input | 1 | RX FIFO push strobe |
| eot_mode | input | 1 | End-of-transmission mode for the transmit flag |
| ser_idle | input | 1 | Transmit serializer idle, stop bit finished |
| tx_clr | input | 1 | Write-one-to-clear for the transmit flag |
| rx_clr | input | 1 | Write-one-to-clear for the receive flag |
| tx_irq | output | 1 | Sticky transmit raw interrupt flag |
| rx_irq | output | 1 | Sticky receive raw interrupt flag |

## Verification
The properties assume the surrounding FIFOs are consistent. A push is never presented with a full receive count, and a pop is never presented with an empty transmit count. The strobes therefore always refer to the occupancy shown on the count inputs in that same cycle. The bench respects this: it presents each strobe alone for one cycle, with a count between 0 and DEPTH, and drops the strobe before the flag is sampled. It changes `ser_idle` and `tx_count` only on the falling edge, so the end-of-transmission edge detector sees clean one-cycle transitions.

// File: rtl/ufl_pkg.sv
// Package for the FIFO threshold interrupt logic.
// Holds the level-code type and the functions that map a code to a fill
// threshold. It assumes depths that are multiples of 8.
package ufl_pkg;

    typedef logic [2:0] lvl_code_t;

    // Highest code with a defined meaning; anything above is reserved.
    localparam lvl_code_t LAST_VALID_CODE = 3'd4;

    // Code is one of the defined trigger levels.
    function automatic logic code_valid(input lvl_code_t code);
        return code <= LAST_VALID_CODE;
    endfunction

    // Receive threshold as filled eighths of the FIFO.
    function automatic int unsigned rx_fill_thr(input lvl_code_t code, input int unsigned depth);
        int unsigned eighths;
        case (code)
            3'd0:    eighths = 1;
            3'd1:    eighths = 2;
            3'd2:    eighths = 4;
            3'd3:    eighths = 6;
            default: eighths = 7;
        endcase
        return (depth * eighths) / 8;
    endfunction

    // Transmit threshold: the code names an empty fraction, converted to a fill.
    function automatic int unsigned tx_fill_thr(input lvl_code_t code, input int unsigned depth);
        int unsigned empty_eighths;
        case (code)
            3'd0:    empty_eighths = 7;
            3'd1:    empty_eighths = 6;
            3'd2:    empty_eighths = 4;
            3'd3:    empty_eighths = 2;
            default: empty_eighths = 1;
        endcase
        return depth - (depth * empty_eighths) / 8;
    endfunction

endpackage

// File: rtl/ufl_level_reg.sv
// Level-select register with one 3-bit code per direction.
// It stores whatever is written, reserved codes included. A write is visible
// from the next cycle. Reset is synchronous and active low.
module ufl_level_reg
    import ufl_pkg::*;
#(
    parameter lvl_code_t RST_TX_CODE = 3'd2,
    parameter lvl_code_t RST_RX_CODE = 3'd2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  logic [5:0] wdata,
    output logic [5:0] rdata,
    output lvl_code_t tx_code,
    output lvl_code_t rx_code
);

    logic [5:0] lvl_q;

    // Hold the register, loading it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= {RST_RX_CODE, RST_TX_CODE};
        end else if (we) begin
            lvl_q <= wdata;
        end
    end

    assign rdata   = lvl_q;
    assign tx_code = lvl_q[2:0];
    assign rx_code = lvl_q[5:3];

endmodule

// File: rtl/ufl_cross_det.sv
// Threshold crossing detector for one FIFO direction.
// FILLING=1 flags a push that brings the occupancy up to the threshold.
// FILLING=0 flags a pop that brings it down to the threshold.
// The count input is the occupancy before the strobe takes effect.
// Reserved codes never flag. The output is combinational.
module ufl_cross_det
    import ufl_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter bit          FILLING = 1'b1,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  lvl_code_t        code,
    input  logic [CNT_W-1:0] count,
    input  logic             strobe,
    output logic             hit
);

    logic [CNT_W-1:0] target;

    generate
        if (FILLING) begin : g_fill
            // Pre-push count that lands exactly on the receive threshold.
            always_comb target = CNT_W'(rx_fill_thr(code, DEPTH) - 1);
        end else begin : g_drain
            // Pre-pop count that lands exactly on the transmit threshold.
            always_comb target = CNT_W'(tx_fill_thr(code, DEPTH) + 1);
        end
    endgenerate

    // A crossing needs a strobe, a defined code and the matching count.
    always_comb hit = strobe && code_valid(code) && (count == target);

endmodule

// File: rtl/ufl_eot_det.sv
// End-of-transmission edge detector.
// It pulses for one cycle when "FIFO empty and serializer idle" goes from
// false to true. Its history register resets to "true", so a block that
// comes out of reset already idle does not raise a spurious event.
module ufl_eot_det #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             ser_idle,
    output logic             rise
);

    logic done_now;
    logic done_q;

    assign done_now = (count == '0) && ser_idle;

    // Remember last cycle's drain-complete condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
        end else begin
            done_q <= done_now;
        end
    end

    assign rise = done_now && !done_q;

endmodule

// File: rtl/uart_fifo_level_irq.sv
// UART FIFO threshold interrupt generator (top).
// It combines the level register, two crossing detectors and the
// end-of-transmission detector into two sticky raw flags with
// write-one-to-clear. A set event beats a clear in the same cycle.
// It assumes the count inputs are the occupancies before this cycle's strobes.
module uart_fifo_level_irq #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [5:0]       cfg_wdata,
    output logic [5:0]       cfg_rdata,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tx_pop,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             eot_mode,
    input  logic             ser_idle,
    input  logic             tx_clr,
    input  logic             rx_clr,
    output logic             tx_irq,
    output logic             rx_irq
);
    import ufl_pkg::*;

    lvl_code_t tx_code;
    lvl_code_t rx_code;
    logic      tx_hit;
    logic      rx_hit;
    logic      eot_rise;
    logic      tx_set;
    logic      tx_irq_q;
    logic      rx_irq_q;

    ufl_level_reg #(
        .RST_TX_CODE (3'd2),
        .RST_RX_CODE (3'd2)
    ) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .tx_code (tx_code),
        .rx_code (rx_code)
    );

    ufl_cross_det #(.DEPTH(DEPTH), .FILLING(1'b1)) u_rx_det (
        .code   (rx_code),
        .count  (rx_count),
        .strobe (rx_push),
        .hit    (rx_hit)
    );

    ufl_cross_det #(.DEPTH(DEPTH), .FILLING(1'b0)) u_tx_det (
        .code   (tx_code),
        .count  (tx_count),
        .strobe (tx_pop),
        .hit    (tx_hit)
    );

    ufl_eot_det #(.CNT_W(CNT_W)) u_eot (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (tx_count),
        .ser_idle (ser_idle),
        .rise     (eot_rise)
    );

    // The transmit source depends on the end-of-transmission mode.
    assign tx_set = eot_mode ? eot_rise : tx_hit;

    // Sticky flags: a set event wins, otherwise the W1C pulse clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq_q <= 1'b0;
            rx_irq_q <= 1'b0;
        end else begin
            tx_irq_q <= tx_set | (tx_irq_q & ~tx_clr);
            rx_irq_q <= rx_hit | (rx_irq_q & ~rx_clr);
        end
    end

    assign tx_irq = tx_irq_q;
    assign rx_irq = rx_irq_q;

endmodule

// File: rtl/ufl_irq_chk.sv
// Property checker for uart_fifo_level_irq, attached by bind.
// It assumes the surrounding FIFOs never push when full or pop when empty.
module ufl_irq_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [5:0]       cfg_rdata,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_pop,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_push,
    input logic             eot_mode,
    input logic             ser_idle,
    input logic             tx_clr,
    input logic             rx_clr,
    input logic             tx_irq,
    input logic             rx_irq
);

    // R3 / R5: the receive flag only rises after a push at a non-full count.
    a_r3_rx_rise_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> ($past(rx_push) && ($past(rx_count) < DEPTH)));

    // R4 / R5: outside end-of-transmission mode, the transmit flag only rises after a pop.
    a_r4_tx_rise_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_irq) && !$past(eot_mode)) |-> ($past(tx_pop) && ($past(tx_count) != '0)));

    // R6: a push under a reserved receive code leaves a clear flag clear.
    a_r6_rx_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_irq && rx_push && (cfg_rdata[5:3] > 3'd4) && !cfg_we) |=> !rx_irq);

    // R7: in end-of-transmission mode the flag rises only once the FIFO is drained and idle.
    a_r7_eot_rise_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_irq) && $past(eot_mode)) |-> ($past(tx_count) == '0 && $past(ser_idle)));

    // R8: without a clear, a set receive flag holds.
    a_r8_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rx_clr) |=> rx_irq);

    // R8: without a clear, a set transmit flag holds.
    a_r8_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !tx_clr) |=> tx_irq);

    // R9: a register write without a push leaves a clear receive flag clear.
    a_r9_write_no_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !rx_push && !rx_irq) |=> !rx_irq);

endmodule

bind uart_fifo_level_irq ufl_irq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_fifo_level_irq_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module uart_fifo_level_irq_bench;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned NVEC  = 25;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [5:0]       cfg_wdata = '0;
    logic [5:0]       cfg_rdata;
    logic [CNT_W-1:0] tx_count = '0;
    logic             tx_pop = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_push = 1'b0;
    logic             eot_mode = 1'b0;
    logic             ser_idle = 1'b0;
    logic             tx_clr = 1'b0;
    logic             rx_clr = 1'b0;
    logic             tx_irq;
    logic             rx_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Vector: {is_tx, code[2:0], pre-strobe count[4:0], expected flag}
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        {1'b0, 3'd0, 5'd1,  1'b1}, {1'b0, 3'd0, 5'd2,  1'b0},
        {1'b0, 3'd1, 5'd3,  1'b1}, {1'b0, 3'd1, 5'd4,  1'b0},
        {1'b0, 3'd2, 5'd7,  1'b1}, {1'b0, 3'd2, 5'd8,  1'b0},
        {1'b0, 3'd2, 5'd6,  1'b0}, {1'b0, 3'd3, 5'd11, 1'b1},
        {1'b0, 3'd3, 5'd12, 1'b0}, {1'b0, 3'd4, 5'd13, 1'b1},
        {1'b0, 3'd4, 5'd15, 1'b0}, {1'b0, 3'd5, 5'd7,  1'b0},
        {1'b0, 3'd6, 5'd15, 1'b0}, {1'b0, 3'd7, 5'd1,  1'b0},
        {1'b1, 3'd0, 5'd3,  1'b1}, {1'b1, 3'd0, 5'd2,  1'b0},
        {1'b1, 3'd1, 5'd5,  1'b1}, {1'b1, 3'd2, 5'd9,  1'b1},
        {1'b1, 3'd2, 5'd8,  1'b0}, {1'b1, 3'd2, 5'd10, 1'b0},
        {1'b1, 3'd3, 5'd13, 1'b1}, {1'b1, 3'd4, 5'd15, 1'b1},
        {1'b1, 3'd4, 5'd14, 1'b0}, {1'b1, 3'd5, 5'd9,  1'b0},
        {1'b1, 3'd7, 5'd3,  1'b0}
    };

    uart_fifo_level_irq #(.DEPTH(DEPTH)) u_uart_fifo_level_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tx_count  (tx_count),
        .tx_pop    (tx_pop),
        .rx_count  (rx_count),
        .rx_push   (rx_push),
        .eot_mode  (eot_mode),
        .ser_idle  (ser_idle),
        .tx_clr    (tx_clr),
        .rx_clr    (rx_clr),
        .tx_irq    (tx_irq),
        .rx_irq    (rx_irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: edge, then settle to the falling edge for sampling and driving.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_both();
        tx_clr = 1'b1;
        rx_clr = 1'b1;
        step();
        tx_clr = 1'b0;
        rx_clr = 1'b0;
    endtask

    task automatic write_cfg(input logic [5:0] val);
        cfg_we    = 1'b1;
        cfg_wdata = val;
        step();
        cfg_we    = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        step();
        rst_n = 1'b1;
        // R1: reset values.
        check("R1 cfg reset", {2'b0, cfg_rdata}, 8'h12);
        check("R1 tx_irq reset", {7'b0, tx_irq}, 8'h0);
        check("R1 rx_irq reset", {7'b0, rx_irq}, 8'h0);

        // R2: readback of reserved codes in both fields.
        write_cfg(6'b111_101);
        check("R2 readback", {2'b0, cfg_rdata}, 8'h3d);

        // R3 R4 R6: table of single-strobe crossings.
        for (int i = 0; i < NVEC; i++) begin
            write_cfg({VEC[i][8:6], VEC[i][8:6]});
            clear_both();
            if (VEC[i][9]) begin
                tx_count = VEC[i][5:1];
                tx_pop   = 1'b1;
            end else begin
                rx_count = VEC[i][5:1];
                rx_push  = 1'b1;
            end
            step();
            tx_pop  = 1'b0;
            rx_push = 1'b0;
            if (VEC[i][9]) begin
                check("R4/R6 tx crossing", {7'b0, tx_irq}, {7'b0, VEC[i][0]});
                check("R4 rx untouched", {7'b0, rx_irq}, 8'h0);
            end else begin
                check("R3/R6 rx crossing", {7'b0, rx_irq}, {7'b0, VEC[i][0]});
                check("R3 tx untouched", {7'b0, tx_irq}, 8'h0);
            end
        end
        tx_count = '0;
        rx_count = '0;

        // R5: counts held without strobes never raise a flag.
        write_cfg(6'b010_010);
        clear_both();
        rx_count = 5'd8;
        tx_count = 5'd8;
        repeat (4) step();
        check("R5 rx level only", {7'b0, rx_irq}, 8'h0);
        check("R5 tx level only", {7'b0, tx_irq}, 8'h0);

        // R8: sticky, cleared by pulse, set wins over clear.
        rx_count = 5'd7;
        rx_push  = 1'b1;
        step();
        rx_push  = 1'b0;
        step();
        check("R8 rx holds", {7'b0, rx_irq}, 8'h1);
        rx_clr = 1'b1;
        step();
        rx_clr = 1'b0;
        check("R8 rx cleared", {7'b0, rx_irq}, 8'h0);
        rx_push = 1'b1;
        step();
        rx_push = 1'b0;
        rx_clr  = 1'b1;
        rx_push = 1'b1;
        step();
        rx_clr  = 1'b0;
        rx_push = 1'b0;
        check("R8 set beats clear", {7'b0, rx_irq}, 8'h1);
        clear_both();

        // R9: write alone is silent; same-cycle push uses the old code.
        rx_count = 5'd3;
        write_cfg(6'b001_010);
        check("R9 write silent", {7'b0, rx_irq}, 8'h0);
        write_cfg(6'b010_010);
        cfg_we    = 1'b1;
        cfg_wdata = 6'b001_010;
        rx_push   = 1'b1;
        step();
        cfg_we  = 1'b0;
        rx_push = 1'b0;
        check("R9 old code on write cycle", {7'b0, rx_irq}, 8'h0);
        rx_push = 1'b1;
        step();
        rx_push = 1'b0;
        check("R9 new code next push", {7'b0, rx_irq}, 8'h1);
        clear_both();

        // R7: end-of-transmission mode.
        eot_mode = 1'b1;
        ser_idle = 1'b0;
        tx_count = 5'd9;
        tx_pop   = 1'b1;
        step();
        tx_pop   = 1'b0;
        check("R7 pop ignored", {7'b0, tx_irq}, 8'h0);
        tx_count = 5'd1;
        ser_idle = 1'b1;
        step();
        check("R7 not empty", {7'b0, tx_irq}, 8'h0);
        tx_count = 5'd0;
        step();
        check("R7 drained and idle", {7'b0, tx_irq}, 8'h1);
        tx_clr = 1'b1;
        step();
        tx_clr = 1'b0;
        repeat (3) step();
        check("R7 no repeat while held", {7'b0, tx_irq}, 8'h0);
        ser_idle = 1'b0;
        step();
        ser_idle = 1'b1;
        step();
        check("R7 second edge", {7'b0, tx_irq}, 8'h1);

        done = 1'b1;
        finish_run();
    end

endmodule